// File: doc/BRIEF.md
# Scatter Segment Descriptor Splitter

This block converts a list of host memory segments into a batch of DMA descriptors for a fixed-size descriptor table. The caller stores the segments elsewhere and gives the block a read port. The block drives a segment index out. The host address and byte length of that segment come back in the same cycle. A batch begins with a start pulse. The pulse carries the direction, the number of segments, a resume point (segment index and byte offset) and the device address that matches that resume point.

Each segment is cut into chunks of at most 0xFFF00 bytes, which is 1 MiB less 256 bytes. Each chunk gives one descriptor. Descriptors are numbered from 0 upward and go out one per cycle. The host and device addresses are routed to source and destination according to the direction. The device address runs on without gaps from one segment to the next. The batch ends when the table is full, when the last segment is fully covered, or when an error is found. A one-cycle done pulse then reports the descriptor count, a completion flag and the exact point at which the next batch must resume. That point can be fed straight back as the next start's resume point.

Top module: `ssd_splitter`

## Requirements
- R1: No descriptor covers more than 0xFFF00 bytes. A segment with R bytes left to cover gives chunks of exactly 0xFFF00 bytes, followed by one final chunk of whatever remains.
- R2: Descriptor IDs in a batch start at 0 and rise by one for each descriptor.
- R3: When `dir_to_dev` is 1, the source is the host address and the destination is the device address. When `dir_to_dev` is 0, the two are swapped.
- R4: Within a segment, each chunk's host address is the previous chunk's host address plus the previous chunk's length. Across all segments, each chunk's device address is the previous one plus the previous length, starting at `dev_start`.
- R5: `desc_words` equals the chunk's byte count divided by 4.
- R6: At most 128 descriptors are built per batch. When the 128th is built before the work is finished, done reports `done_all`=0, `done_count`=128, `done_idx` as the segment in use, and `done_off` as the bytes of that segment covered so far.
- R7: A batch that resumes at offset F of segment S starts at host address base+F. If F equals the segment's length, that segment is skipped without building a descriptor.
- R8: The batch ends with `done_err`=1 and builds no further descriptor in any of these cases: a resume index not below `seg_count`; a resume offset or `dev_start` that is not a multiple of 4; a segment whose address or length is not a multiple of 4; a resume offset larger than the segment's length. `done_idx`/`done_off` give the point at which the fault was found, and `done_count` gives the descriptors already built.
- R9: A zero-length segment builds no descriptor, and the device address does not advance for it.
- R10: `done` is held low from reset. It rises for one cycle at the end of each batch, together with the last descriptor if there is one. When the last segment is fully covered, `done_all`=1, `done_idx` is the last index and `done_off` is that segment's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a batch; accepted only while idle |
| dir_to_dev | input | 1 | 1: host to device, 0: device to host |
| seg_count | input | IDX_W | Number of segments in the list |
| resume_idx | input | IDX_W | Segment at which the batch starts |
| resume_off | input | LEN_W | Byte offset into that segment |
| dev_start | input | ADDR_W | Device address at the resume point |
| seg_rd_idx | output | IDX_W | Segment index being read |
| seg_host_addr | input | ADDR_W | Host address of segment `seg_rd_idx` |
| seg_len | input | LEN_W | Byte length of segment `seg_rd_idx` |
| desc_valid | output | 1 | Descriptor write strobe |
| desc_id | output | ID_W | Table slot of the descriptor |
| desc_src | output | ADDR_W | Source address |
| desc_dst | output | ADDR_W | Destination address |
| desc_words | output | WORDS_W | Length in 32-bit words |
| done | output | 1 | End-of-batch pulse |
| done_err | output | 1 | Batch ended on a fault |
| done_all | output | 1 | Last segment fully covered |
| done_count | output | CNT_W | Descriptors built in the batch |
| done_idx | output | IDX_W | Resume segment index |
| done_off | output | LEN_W | Resume byte offset |

## Verification
Lists of short segments in both directions tell a correct source/destination swap and a correct device-address carry from errors where only one side is right. A multi-megabyte segment brings out the non-power-of-two chunk cut and the odd-sized tail. Two table-full cases separate a stop that falls exactly at a segment end from one inside a segment, and the matching resumed batches show whether the skip and offset rules continue correctly. Zero-length segments in the middle and at the end of a list, and faults found before and after some descriptors are out, show whether the reported stop point and count stay exact.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } ssd_state_e;
endpackage

// File: rtl/ssd_chunk_calc.sv
// Per-segment arithmetic: what is left, how much fits into one descriptor,
// and whether the segment as presented is legal.
module ssd_chunk_calc #(
    parameter int LEN_W     = 32,
    parameter int MAX_CHUNK = 32'hFFF00
) (
    input  logic [1:0]       addr_lsb,
    input  logic [LEN_W-1:0] seg_len,
    input  logic [LEN_W-1:0] off,
    output logic             bad,
    output logic             rem_zero,
    output logic             tail,
    output logic [LEN_W-1:0] chunk
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_CHUNK);

    logic [LEN_W-1:0] remain;
    logic             big;

    always_comb begin
        remain   = seg_len - off;
        bad      = (|addr_lsb) || (|seg_len[1:0]) || (|off[1:0]) || (off > seg_len);
        rem_zero = (remain == '0);
        big      = (remain > MAX_L);
        chunk    = big ? MAX_L : remain;
        tail     = !big;
    end
endmodule

// File: rtl/ssd_addr_route.sv
// Maps host/device addresses onto source/destination by direction.
module ssd_addr_route #(
    parameter int ADDR_W = 64
) (
    input  logic              to_dev,
    input  logic [ADDR_W-1:0] host,
    input  logic [ADDR_W-1:0] dev,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst
);
    always_comb begin
        src = to_dev ? host : dev;
        dst = to_dev ? dev  : host;
    end
endmodule

// File: rtl/ssd_splitter.sv
module ssd_splitter #(
    parameter int ADDR_W    = 64,
    parameter int LEN_W     = 32,
    parameter int IDX_W     = 16,
    parameter int DEPTH     = 128,
    parameter int MAX_CHUNK = 32'hFFF00,
    localparam int ID_W     = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int WORDS_W  = $clog2(MAX_CHUNK / 4 + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dir_to_dev,
    input  logic [IDX_W-1:0]   seg_count,
    input  logic [IDX_W-1:0]   resume_idx,
    input  logic [LEN_W-1:0]   resume_off,
    input  logic [ADDR_W-1:0]  dev_start,
    output logic [IDX_W-1:0]   seg_rd_idx,
    input  logic [ADDR_W-1:0]  seg_host_addr,
    input  logic [LEN_W-1:0]   seg_len,
    output logic               desc_valid,
    output logic [ID_W-1:0]    desc_id,
    output logic [ADDR_W-1:0]  desc_src,
    output logic [ADDR_W-1:0]  desc_dst,
    output logic [WORDS_W-1:0] desc_words,
    output logic               done,
    output logic               done_err,
    output logic               done_all,
    output logic [CNT_W-1:0]   done_count,
    output logic [IDX_W-1:0]   done_idx,
    output logic [LEN_W-1:0]   done_off
);
    import ssd_pkg::*;

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);

    typedef struct packed {
        ssd_state_e         st;
        logic               dir;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic [LEN_W-1:0]   off;
        logic [ADDR_W-1:0]  dev;
        logic [CNT_W-1:0]   cnt;
        logic               dv;
        logic [ID_W-1:0]    did;
        logic [ADDR_W-1:0]  dsrc;
        logic [ADDR_W-1:0]  ddst;
        logic [WORDS_W-1:0] dwords;
        logic               fin;
        logic               ferr;
        logic               fall;
        logic [CNT_W-1:0]   fcnt;
        logic [IDX_W-1:0]   fidx;
        logic [LEN_W-1:0]   foff;
    } ssd_regs_t;

    ssd_regs_t q, d;

    logic             c_bad, c_rem_zero, c_tail;
    logic [LEN_W-1:0] c_chunk;
    logic [ADDR_W-1:0] host_cur, r_src, r_dst;

    ssd_chunk_calc #(
        .LEN_W    (LEN_W),
        .MAX_CHUNK(MAX_CHUNK)
    ) u_chunk (
        .addr_lsb(seg_host_addr[1:0]),
        .seg_len (seg_len),
        .off     (q.off),
        .bad     (c_bad),
        .rem_zero(c_rem_zero),
        .tail    (c_tail),
        .chunk   (c_chunk)
    );

    assign host_cur = seg_host_addr + ADDR_W'(q.off);

    ssd_addr_route #(
        .ADDR_W(ADDR_W)
    ) u_route (
        .to_dev(q.dir),
        .host  (host_cur),
        .dev   (q.dev),
        .src   (r_src),
        .dst   (r_dst)
    );

    logic [LEN_W-1:0] new_off;
    logic             is_last_seg;

    always_comb begin
        d           = q;
        d.dv        = 1'b0;
        d.fin       = 1'b0;
        new_off     = q.off + c_chunk;
        is_last_seg = (q.idx == q.last);
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.dir  = dir_to_dev;
                    d.idx  = resume_idx;
                    d.off  = resume_off;
                    d.dev  = dev_start;
                    d.cnt  = '0;
                    d.last = seg_count - 1'b1;
                    if ((resume_idx >= seg_count) || (|resume_off[1:0]) || (|dev_start[1:0])) begin
                        d.fin  = 1'b1;
                        d.ferr = 1'b1;
                        d.fall = 1'b0;
                        d.fcnt = '0;
                        d.fidx = resume_idx;
                        d.foff = resume_off;
                    end else begin
                        d.st = S_RUN;
                    end
                end
            end
            S_RUN: begin
                if (c_bad) begin
                    d.st   = S_IDLE;
                    d.fin  = 1'b1;
                    d.ferr = 1'b1;
                    d.fall = 1'b0;
                    d.fcnt = q.cnt;
                    d.fidx = q.idx;
                    d.foff = q.off;
                end else if (c_rem_zero) begin
                    if (is_last_seg) begin
                        d.st   = S_IDLE;
                        d.fin  = 1'b1;
                        d.ferr = 1'b0;
                        d.fall = 1'b1;
                        d.fcnt = q.cnt;
                        d.fidx = q.idx;
                        d.foff = q.off;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.off = '0;
                    end
                end else begin
                    d.dv     = 1'b1;
                    d.did    = ID_W'(q.cnt);
                    d.dsrc   = r_src;
                    d.ddst   = r_dst;
                    d.dwords = WORDS_W'(c_chunk >> 2);
                    d.dev    = q.dev + ADDR_W'(c_chunk);
                    d.cnt    = q.cnt + 1'b1;
                    if ((c_tail && is_last_seg) || (q.cnt == LAST_SLOT)) begin
                        d.st   = S_IDLE;
                        d.fin  = 1'b1;
                        d.ferr = 1'b0;
                        d.fall = c_tail && is_last_seg;
                        d.fcnt = q.cnt + 1'b1;
                        d.fidx = q.idx;
                        d.foff = new_off;
                    end else if (c_tail) begin
                        d.idx = q.idx + 1'b1;
                        d.off = '0;
                    end else begin
                        d.off = new_off;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign seg_rd_idx = q.idx;
    assign desc_valid = q.dv;
    assign desc_id    = q.did;
    assign desc_src   = q.dsrc;
    assign desc_dst   = q.ddst;
    assign desc_words = q.dwords;
    assign done       = q.fin;
    assign done_err   = q.ferr;
    assign done_all   = q.fall;
    assign done_count = q.fcnt;
    assign done_idx   = q.fidx;
    assign done_off   = q.foff;
endmodule

// File: rtl/ssd_splitter_chk.sv
module ssd_splitter_chk #(
    parameter int ADDR_W    = 64,
    parameter int DEPTH     = 128,
    parameter int MAX_CHUNK = 32'hFFF00,
    parameter int ID_W      = 7,
    parameter int CNT_W     = 8,
    parameter int WORDS_W   = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               desc_valid,
    input logic [ID_W-1:0]    desc_id,
    input logic [ADDR_W-1:0]  desc_src,
    input logic [ADDR_W-1:0]  desc_dst,
    input logic [WORDS_W-1:0] desc_words,
    input logic               done,
    input logic               done_err,
    input logic               done_all,
    input logic [CNT_W-1:0]   done_count
);
    localparam logic [WORDS_W-1:0] MAX_WORDS = WORDS_W'(MAX_CHUNK / 4);

    logic [CNT_W-1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else if (done) seen_q <= '0;
        else if (desc_valid) seen_q <= seen_q + 1'b1;
    end

    p_chunk_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_words != '0) && (desc_words <= MAX_WORDS));

    p_id_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && $past(desc_valid) |-> desc_id == ID_W'($past(desc_id) + 1'b1));

    p_addr_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && $past(desc_valid) |->
            (desc_src == $past(desc_src) + ADDR_W'({$past(desc_words), 2'b00})) ||
            (desc_dst == $past(desc_dst) + ADDR_W'({$past(desc_words), 2'b00})));

    p_full_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_err && !done_all |-> done_count == CNT_W'(DEPTH));

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_err |-> !desc_valid);

    p_count_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_count == seen_q + CNT_W'(desc_valid));
endmodule

bind ssd_splitter ssd_splitter_chk #(
    .ADDR_W   (ADDR_W),
    .DEPTH    (DEPTH),
    .MAX_CHUNK(MAX_CHUNK),
    .ID_W     (ID_W),
    .CNT_W    (CNT_W),
    .WORDS_W  (WORDS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_valid(desc_valid),
    .desc_id   (desc_id),
    .desc_src  (desc_src),
    .desc_dst  (desc_dst),
    .desc_words(desc_words),
    .done      (done),
    .done_err  (done_err),
    .done_all  (done_all),
    .done_count(done_count)
);

// File: tb/tb_ssd_splitter.sv
module tb_ssd_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG       = 160;
    localparam int TBL        = 128;
    localparam logic [31:0] MAXC = 32'hFFF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_to_dev = 1'b0;
    logic [15:0] seg_count = '0;
    logic [15:0] resume_idx = '0;
    logic [31:0] resume_off = '0;
    logic [63:0] dev_start = '0;
    logic [15:0] seg_rd_idx;
    logic [63:0] seg_host_addr;
    logic [31:0] seg_len;
    logic        desc_valid;
    logic [6:0]  desc_id;
    logic [63:0] desc_src, desc_dst;
    logic [17:0] desc_words;
    logic        done, done_err, done_all;
    logic [7:0]  done_count;
    logic [15:0] done_idx;
    logic [31:0] done_off;

    logic [63:0] sm_a [NSEG];
    logic [31:0] sm_l [NSEG];

    assign seg_host_addr = (seg_rd_idx < NSEG) ? sm_a[seg_rd_idx] : '0;
    assign seg_len       = (seg_rd_idx < NSEG) ? sm_l[seg_rd_idx] : '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ssd_splitter dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_to_dev(dir_to_dev),
        .seg_count(seg_count), .resume_idx(resume_idx), .resume_off(resume_off),
        .dev_start(dev_start), .seg_rd_idx(seg_rd_idx), .seg_host_addr(seg_host_addr),
        .seg_len(seg_len), .desc_valid(desc_valid), .desc_id(desc_id),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_words(desc_words),
        .done(done), .done_err(done_err), .done_all(done_all),
        .done_count(done_count), .done_idx(done_idx), .done_off(done_off)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // captured outputs
    int          got_n;
    bit          got_done;
    logic [6:0]  g_id [TBL];
    logic [63:0] g_src [TBL];
    logic [63:0] g_dst [TBL];
    logic [17:0] g_w [TBL];
    logic        g_err, g_all;
    logic [7:0]  g_cnt;
    logic [15:0] g_idx;
    logic [31:0] g_off;

    always @(negedge clk) begin
        if (desc_valid) begin
            if (got_n < TBL) begin
                g_id[got_n]  = desc_id;
                g_src[got_n] = desc_src;
                g_dst[got_n] = desc_dst;
                g_w[got_n]   = desc_words;
            end
            got_n++;
        end
        if (done) begin
            got_done = 1'b1;
            g_err = done_err; g_all = done_all; g_cnt = done_count;
            g_idx = done_idx; g_off = done_off;
        end
    end

    // reference model built from the requirements
    int          e_n;
    logic [63:0] e_src [TBL];
    logic [63:0] e_dst [TBL];
    logic [31:0] e_bytes [TBL];
    bit          e_err, e_all;
    int          e_idx;
    logic [31:0] e_off;

    task automatic model(input bit dir, input int n, input int ridx,
                         input logic [31:0] roff, input logic [63:0] dev0);
        int          i;
        logic [31:0] off, l, ch;
        logic [63:0] dev, h;
        e_n = 0; e_err = 0; e_all = 0; i = ridx; off = roff; dev = dev0;
        if (ridx >= n || roff[1:0] != 0 || dev0[1:0] != 0) begin
            e_err = 1;
        end else begin
            forever begin
                l = sm_l[i];
                if (sm_a[i][1:0] != 0 || l[1:0] != 0 || off > l) begin
                    e_err = 1; break;
                end
                while (off < l && e_n < TBL) begin
                    ch = (l - off > MAXC) ? MAXC : l - off;
                    h = sm_a[i] + 64'(off);
                    e_src[e_n] = dir ? h : dev;
                    e_dst[e_n] = dir ? dev : h;
                    e_bytes[e_n] = ch;
                    off += ch; dev += 64'(ch); e_n++;
                end
                if (off == l && i == n - 1) begin e_all = 1; break; end
                if (e_n == TBL) break;
                i++; off = 0;
            end
        end
        e_idx = i; e_off = off;
    endtask

    task automatic run_batch(input string req, input bit dir, input int n,
                             input int ridx, input logic [31:0] roff, input logic [63:0] dev0);
        int waited = 0;
        model(dir, n, ridx, roff, dev0);
        got_n = 0; got_done = 0;
        dir_to_dev = dir; seg_count = 16'(n); resume_idx = 16'(ridx);
        resume_off = roff; dev_start = dev0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got_done && waited < 2000) begin
            @(negedge clk); #1; waited++;
        end
        check(got_done, req, "done seen", 64'(got_done), 1);
        check(got_n == e_n, req, "descriptor count", 64'(got_n), 64'(e_n));
        for (int k = 0; k < e_n && k < got_n; k++) begin
            check(g_id[k] == 7'(k), req, "desc id (R2)", 64'(g_id[k]), 64'(k));
            check(g_src[k] == e_src[k], req, "desc src (R3/R4)", g_src[k], e_src[k]);
            check(g_dst[k] == e_dst[k], req, "desc dst (R3/R4)", g_dst[k], e_dst[k]);
            check(g_w[k] == 18'(e_bytes[k] >> 2), req, "desc words (R5)", 64'(g_w[k]), 64'(e_bytes[k] >> 2));
        end
        check(g_err == e_err, req, "done_err", 64'(g_err), 64'(e_err));
        check(g_all == e_all, req, "done_all", 64'(g_all), 64'(e_all));
        check(g_cnt == 8'(e_n), req, "done_count", 64'(g_cnt), 64'(e_n));
        check(g_idx == 16'(e_idx), req, "done_idx", 64'(g_idx), 64'(e_idx));
        check(g_off == e_off, req, "done_off", 64'(g_off), 64'(e_off));
        @(negedge clk);
        check(done == 1'b0, "R10", "done single cycle", 64'(done), 0);
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R10", "done after reset", 64'(done), 0);
        check(desc_valid == 1'b0, "R2", "desc_valid after reset", 64'(desc_valid), 0);
    endtask

    task automatic t_basic();
        sm_a[0] = 64'h1000_0000; sm_l[0] = 32'h100;
        sm_a[1] = 64'h2000_0040; sm_l[1] = 32'h40;
        sm_a[2] = 64'h3000_0000; sm_l[2] = 32'h1000;
        run_batch("R3", 1'b1, 3, 0, 0, 64'h8000_0000);
        run_batch("R3", 1'b0, 3, 0, 0, 64'h8000_2000);
    endtask

    task automatic t_large();
        sm_a[0] = 64'h1_0000_0000; sm_l[0] = 32'h250000;
        sm_a[1] = 64'h2_0000_0000; sm_l[1] = MAXC;
        run_batch("R1", 1'b1, 2, 0, 0, 64'h4000);
    endtask

    task automatic t_zero();
        sm_a[0] = 64'h5000; sm_l[0] = 32'h20;
        sm_a[1] = 64'h6000; sm_l[1] = 32'h0;
        sm_a[2] = 64'h7000; sm_l[2] = 32'h10;
        sm_a[3] = 64'h9000; sm_l[3] = 32'h0;
        run_batch("R9", 1'b0, 4, 0, 0, 64'hA000);
    endtask

    task automatic t_full_edge();
        for (int k = 0; k < 130; k++) begin
            sm_a[k] = 64'h10_0000 + 64'(k) * 64'h100; sm_l[k] = 32'h8;
        end
        run_batch("R6", 1'b1, 130, 0, 0, 64'h2_0000);
        run_batch("R7", 1'b1, 130, 127, 32'h8, 64'h2_0000 + 64'd1024);
    endtask

    task automatic t_full_mid();
        sm_a[0] = 64'h1_0000_0000; sm_l[0] = MAXC * 129;
        run_batch("R6", 1'b0, 1, 0, 0, 64'h0);
        run_batch("R7", 1'b0, 1, 0, MAXC * 128, 64'(MAXC) * 128);
    endtask

    task automatic t_resume_off();
        sm_a[0] = 64'hC000; sm_l[0] = 32'h100;
        sm_a[1] = 64'hD000; sm_l[1] = 32'h8;
        run_batch("R7", 1'b1, 2, 0, 32'h20, 64'hE020);
    endtask

    task automatic t_errors();
        sm_a[0] = 64'h1000; sm_l[0] = 32'h100;
        sm_a[1] = 64'h2000; sm_l[1] = 32'h42;
        run_batch("R8", 1'b1, 2, 0, 32'h104, 64'h0);
        sm_l[0] = 32'h40;
        run_batch("R8", 1'b1, 2, 0, 0, 64'h0);
        run_batch("R8", 1'b1, 2, 2, 0, 64'h0);
        run_batch("R8", 1'b1, 2, 0, 0, 64'h1002);
        sm_a[1] = 64'h2002; sm_l[1] = 32'h40;
        run_batch("R8", 1'b0, 2, 0, 0, 64'h0);
    endtask

    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NSEG; k++) begin sm_a[k] = '0; sm_l[k] = '0; end
        got_n = 0; got_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_large();
        t_zero();
        t_full_edge();
        t_full_mid();
        t_resume_off();
        t_errors();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule